// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block is the transmit half of an asynchronous serial port. Software or an upstream engine hands it one byte at a time through a valid/ready handshake. The byte waits in a single-entry holding register until the shifter is free. The shifter then sends one frame on the serial line: a low start bit, the data bits least significant first, an optional parity bit, and the stop bits. One control byte sets the frame format. A 16-bit divisor sets the bit rate.

The divisor counts system clocks per oversample tick. A bit lasts 16 ticks. For a 1.8432 MHz reference clock, divisor = 115200 / baud. The format is captured when a frame starts, so a change to the control byte during a frame only affects later frames. The break control is the exception: it drives the line low at once. Two status outputs let the user pace writes. One shows that the holding register is free. The other shows that the whole transmitter is idle.

The shifter has five states:
- `ST_IDLE`: waiting for a word.
- `ST_START`: sending the start bit.
- `ST_DATA`: sending data bits.
- `ST_PARITY`: sending the parity bit.
- `ST_STOP`: sending the stop period.

Its transitions are:
- idle → start when the holding register is full.
- start → data at the end of the start bit.
- data → parity after the last data bit when parity is enabled.
- data → stop after the last data bit when parity is disabled.
- parity → stop at the end of the parity bit.
- stop → idle at the end of the stop period.

A new frame therefore always follows the previous one after exactly one idle clock.

Top module: `serial_frame_tx`

## Requirements
- R1: Control bits [1:0] select the word length: 00 → 5, 01 → 6, 10 → 7, 11 → 8 data bits. Data bits above the word length are not sent.
- R2: The line idles at 1. A frame starts with one 0 start bit, then the data bits LSB first. Every bit lasts 16 × divisor clocks, and a divisor of 0 behaves as 1.
- R3: When control bit 3 is set, a parity bit follows the last data bit. With bit 5 clear, bit 4 = 1 gives even parity and bit 4 = 0 gives odd parity.
- R4: With bits 3 and 5 set, the parity bit is the constant NOT bit 4. Control 0x28 sends a 1 (mark) and 0x38 sends a 0 (space).
- R5: With control bit 2 clear, the stop period is 1 bit. With bit 2 set, it is 1.5 bits for 5-bit words and 2 bits otherwise. `tx_empty` rises one clock after the stop period ends.
- R6: While control bit 6 is set, `txd` is 0 in the same cycle, whether the transmitter is idle or busy. A frame in progress keeps its timing underneath the break.
- R7: The format bits (0–5) are sampled when a frame starts. Changes during a frame do not alter that frame.
- R8: `in_ready` equals `hold_empty`. A word is accepted when `in_valid` and `in_ready` are both high. The holding register frees up as soon as its word moves to the shifter, so a second word can be accepted while the first is still being sent.
- R9: `tx_empty` is 1 only when the holding register is empty and the shifter is idle.
- R10: After reset, `txd` = 1, `hold_empty` = 1, `tx_empty` = 1 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_ctrl | input | 8 | Frame format and break control byte |
| divisor | input | 16 | Clocks per oversample tick (0 acts as 1) |
| in_data | input | 8 | Word to transmit |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Holding register can accept a word |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register is empty |
| tx_empty | output | 1 | Holding register and shifter are both idle |

## Verification
The bench measures the stop period by the exact clock on which `tx_empty` rises. A shifter that confused 1.5 and 2 stop bits would shift that edge by 8 × divisor clocks, so it would be caught.

Mark and space frames are sent with data that would give the opposite normal parity. A design that ignored bit 5 would therefore send the wrong level.

The format byte is rewritten in the middle of a frame. A design that did not latch the format would change the word length and the frame end.

A break is raised during a frame of all ones and then released. The bench checks that the line drops at once and that the frame still ends on schedule.

A second word is pushed while the first is still shifting. This catches a holding register that frees up too late or overwrites a pending word.

// File: rtl/sft_pkg.sv
`timescale 1ns/1ps
package sft_pkg;

    localparam int WORD_MAX = 8;

    // control byte field positions (decoded by the shifter)
    localparam int CB_STB   = 2;
    localparam int CB_PEN   = 3;
    localparam int CB_EPS   = 4;
    localparam int CB_STICK = 5;
    localparam int CB_BRK   = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    typedef struct packed {
        logic [1:0] len_code;     // word length minus five
        logic       par_en;
        logic       par_val;      // parity level for this word
        logic [2:0] stop_halves;  // stop period in half bits
    } frame_fmt_t;

    function automatic frame_fmt_t decode_fmt(input logic [7:0] ctrl,
                                              input logic [WORD_MAX-1:0] word);
        frame_fmt_t f;
        logic [WORD_MAX-1:0] mask;
        logic ones_odd;
        mask = '0;
        for (int i = 0; i < WORD_MAX; i++) begin
            if (i < 5 + int'(ctrl[1:0])) mask[i] = 1'b1;
        end
        ones_odd   = ^(word & mask);
        f.len_code = ctrl[1:0];
        f.par_en   = ctrl[CB_PEN];
        if (ctrl[CB_STICK])    f.par_val = ~ctrl[CB_EPS];
        else if (ctrl[CB_EPS]) f.par_val = ones_odd;
        else                   f.par_val = ~ones_odd;
        if (!ctrl[CB_STB])           f.stop_halves = 3'd2;
        else if (ctrl[1:0] == 2'b00) f.stop_halves = 3'd3;
        else                         f.stop_halves = 3'd4;
        return f;
    endfunction

endpackage

// File: rtl/sft_baud_gen.sv
`timescale 1ns/1ps
module sft_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_last;

    assign div_last = (divisor == '0) ? '0 : divisor - 1'b1;
    assign tick     = run && (cnt >= div_last);

    // counter is held at zero while idle so every frame starts on a fresh phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (!run)  cnt <= '0;
        else if (tick)  cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor > 16'd1 && $stable(divisor)) |=> !tick);

endmodule

// File: rtl/sft_hold_reg.sv
`timescale 1ns/1ps
module sft_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] word
);
    logic accept;

    assign in_ready = !full;
    assign accept   = in_valid && !full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            word <= '0;
        end else if (accept) begin
            full <= 1'b1;
            word <= in_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take) |=> (full && $stable(word)));

endmodule

// File: rtl/sft_frame_fsm.sv
`timescale 1ns/1ps
module sft_frame_fsm
    import sft_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [7:0]          line_ctrl,
    input  logic                hold_full,
    input  logic [WORD_MAX-1:0] hold_word,
    output logic                load,
    output logic                busy,
    output logic                line_lvl
);
    localparam int TCNT_W = $clog2(2 * OVS);
    localparam int IDX_W  = $clog2(WORD_MAX);

    tx_state_t            state, state_nx;
    logic [TCNT_W-1:0]    tcnt;
    logic [TCNT_W:0]      bit_len;
    logic [IDX_W-1:0]     bit_idx;
    logic [IDX_W-1:0]     last_idx;
    logic [WORD_MAX-1:0]  shreg;
    frame_fmt_t           fmt_q;
    logic                 bit_done;

    assign last_idx = IDX_W'(fmt_q.len_code) + IDX_W'(4);
    assign bit_len  = (state == ST_STOP)
                    ? (TCNT_W+1)'(fmt_q.stop_halves) * (TCNT_W+1)'(OVS / 2)
                    : (TCNT_W+1)'(OVS);
    assign bit_done = tick && ({1'b0, tcnt} == bit_len - 1'b1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (hold_full) state_nx = ST_START;
            ST_START:  if (bit_done)  state_nx = ST_DATA;
            ST_DATA:   if (bit_done && bit_idx == last_idx)
                           state_nx = fmt_q.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_done)  state_nx = ST_STOP;
            ST_STOP:   if (bit_done)  state_nx = ST_IDLE;
            default:                  state_nx = ST_IDLE;
        endcase
    end

    // frame datapath: format, word and position are captured at frame start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt    <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            fmt_q   <= '0;
        end else if (load) begin
            tcnt    <= '0;
            bit_idx <= '0;
            shreg   <= hold_word;
            fmt_q   <= decode_fmt(line_ctrl, hold_word);
        end else if (tick) begin
            if (bit_done) begin
                tcnt <= '0;
                if (state == ST_DATA) begin
                    shreg   <= shreg >> 1;
                    bit_idx <= bit_idx + 1'b1;
                end
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        load     = 1'b0;
        busy     = 1'b1;
        line_lvl = 1'b1;
        unique case (state)
            ST_IDLE:   begin busy = 1'b0; load = hold_full; end
            ST_START:  line_lvl = 1'b0;
            ST_DATA:   line_lvl = shreg[0];
            ST_PARITY: line_lvl = fmt_q.par_val;
            ST_STOP:   line_lvl = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    p_fmt_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(fmt_q));

    p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (bit_idx <= last_idx));

    p_start_from_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && hold_full) |=> (state == ST_START));

    p_tcnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, tcnt} < bit_len));

endmodule

// File: rtl/serial_frame_tx.sv
`timescale 1ns/1ps
module serial_frame_tx
    import sft_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       line_ctrl,
    input  logic [DIV_W-1:0] divisor,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             txd,
    output logic             hold_empty,
    output logic             tx_empty
);
    logic                tick;
    logic                load;
    logic                busy;
    logic                line_lvl;
    logic                hold_full;
    logic [WORD_MAX-1:0] hold_word;

    sft_hold_reg #(.DATA_W(WORD_MAX)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .take     (load),
        .full     (hold_full),
        .word     (hold_word)
    );

    sft_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .divisor (divisor),
        .tick    (tick)
    );

    sft_frame_fsm #(.OVS(OVS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .line_ctrl (line_ctrl),
        .hold_full (hold_full),
        .hold_word (hold_word),
        .load      (load),
        .busy      (busy),
        .line_lvl  (line_lvl)
    );

    assign txd        = line_ctrl[CB_BRK] ? 1'b0 : line_lvl;
    assign hold_empty = !hold_full;
    assign tx_empty   = !hold_full && !busy;

    p_empty_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> hold_empty);

    p_break_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctrl[CB_BRK] |-> !txd);

    p_busy_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !line_ctrl[CB_BRK]) |-> txd);

endmodule

// File: tb/serial_frame_tx_test.sv
`timescale 1ns/1ps
module serial_frame_tx_test;
    localparam int P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  line_ctrl = 8'h03;
    logic [15:0] divisor = 16'd1;
    logic [7:0]  in_data = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_ready, txd, hold_empty, tx_empty;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    serial_frame_tx uut (
        .clk(clk), .rst_n(rst_n), .line_ctrl(line_ctrl), .divisor(divisor),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    always #(P/2) clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                failures++;
                $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
                $finish;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    task automatic wait_to(input time t);
        if (t > $time) #(t - $time);
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_data  = d;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // called right at the falling edge of a start bit
    task automatic frame_body(input logic [7:0] lcr, input logic [7:0] data, input int div,
                              input string req, input bit swap, input logic [7:0] new_lcr);
        time t0;
        int nb, bitp, nbits_total, halves, total;
        logic par;
        logic [7:0] m;
        t0 = $time;
        nb = 5 + int'(lcr[1:0]);
        m = data & 8'((1 << nb) - 1);
        par = lcr[5] ? ~lcr[4] : (lcr[4] ? ^m : ~^m);
        bitp = 16 * div;
        nbits_total = 1 + nb + int'(lcr[3]);
        halves = !lcr[2] ? 2 : (nb == 5 ? 3 : 4);
        total = nbits_total * bitp + halves * 8 * div;
        for (int k = 0; k <= nbits_total; k++) begin
            logic e;
            wait_to(t0 + time'((k * bitp + bitp / 2) * P + P / 2));
            if (k == 0)                     e = 1'b0;
            else if (k <= nb)               e = m[k-1];
            else if (k == nb + 1 && lcr[3]) e = par;
            else                            e = 1'b1;
            check(txd == e, req, int'(txd), int'(e));
            if (swap && k == 2) line_ctrl = new_lcr;
        end
        wait_to(t0 + time'(total * P - P / 2));
        check(txd == 1'b1, {req, " stop level"}, int'(txd), 1);
        check(tx_empty == 1'b0, {req, " R5 busy to stop end"}, int'(tx_empty), 0);
        wait_to(t0 + time'(total * P + P / 2));
        check(tx_empty == 1'b1, {req, " R5 empty after stop"}, int'(tx_empty), 1);
    endtask

    task automatic send_frame(input logic [7:0] lcr, input logic [7:0] data, input int div,
                              input string req);
        line_ctrl = lcr;
        push(data);
        @(negedge txd);
        frame_body(lcr, data, div, req, 1'b0, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check(txd == 1'b1, "R10 txd", int'(txd), 1);
        check(hold_empty == 1'b1, "R10 hold_empty", int'(hold_empty), 1);
        check(tx_empty == 1'b1, "R10 tx_empty", int'(tx_empty), 1);
        check(in_ready == 1'b1, "R10 in_ready", int'(in_ready), 1);
    endtask

    task automatic t_word_len;
        divisor = 16'd1;
        send_frame(8'h03, 8'hA5, 1, "R2 8N1");
        send_frame(8'h00, 8'hE3, 1, "R1 5N1");
        send_frame(8'h01, 8'hD6, 1, "R1 6N1");
        send_frame(8'h02, 8'hB9, 1, "R1 7N1");
    endtask

    task automatic t_parity;
        send_frame(8'h19, 8'h2B, 1, "R3 6E1");
        send_frame(8'h0A, 8'h55, 1, "R3 7O1");
        send_frame(8'h1B, 8'h00, 1, "R3 8E1 zero");
    endtask

    task automatic t_stick;
        // data with odd ones count so normal parity would give the opposite level
        send_frame(8'h2B, 8'h01, 1, "R4 mark");
        send_frame(8'h3B, 8'h07, 1, "R4 space");
    endtask

    task automatic t_stop;
        send_frame(8'h07, 8'h81, 1, "R5 8N2");
        send_frame(8'h04, 8'h15, 1, "R5 5N1.5");
        send_frame(8'h0C, 8'h0A, 1, "R5 5O1.5");
    endtask

    task automatic t_divisor;
        divisor = 16'd3;
        send_frame(8'h1B, 8'h96, 3, "R2 div3");
        divisor = 16'd0;
        send_frame(8'h03, 8'h6C, 1, "R2 div0");
        divisor = 16'd1;
    endtask

    task automatic t_holding;
        time t0;
        line_ctrl = 8'h03;
        push(8'hFF);
        @(negedge txd);
        t0 = $time;
        wait_to(t0 + time'(3 * P + P / 2));
        check(hold_empty == 1'b1, "R8 hold frees at start", int'(hold_empty), 1);
        check(in_ready == 1'b1, "R8 ready while shifting", int'(in_ready), 1);
        check(tx_empty == 1'b0, "R9 busy shifter", int'(tx_empty), 0);
        push(8'h3C);
        check(hold_empty == 1'b0, "R8 second word held", int'(hold_empty), 0);
        check(in_ready == 1'b0, "R8 not ready when full", int'(in_ready), 0);
        check(tx_empty == 1'b0, "R9 both busy", int'(tx_empty), 0);
        @(negedge txd);
        frame_body(8'h03, 8'h3C, 1, "R8 queued word", 1'b0, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_latch;
        line_ctrl = 8'h03;
        push(8'h5A);
        @(negedge txd);
        frame_body(8'h03, 8'h5A, 1, "R7 format held", 1'b1, 8'h1C);
        line_ctrl = 8'h03;
        @(negedge clk);
    endtask

    task automatic t_break;
        time t0;
        @(negedge clk);
        line_ctrl = 8'h43;
        #1;
        check(txd == 1'b0, "R6 break at idle", int'(txd), 0);
        check(tx_empty == 1'b1, "R6 idle under break", int'(tx_empty), 1);
        @(negedge clk);
        line_ctrl = 8'h03;
        #1;
        check(txd == 1'b1, "R6 release at idle", int'(txd), 1);
        push(8'hFF);
        @(negedge txd);
        t0 = $time;
        wait_to(t0 + time'((3 * 16 + 8) * P + P / 2));
        line_ctrl = 8'h43;
        #1;
        check(txd == 1'b0, "R6 break mid frame", int'(txd), 0);
        wait_to(t0 + time'((5 * 16 + 8) * P + P / 2));
        check(txd == 1'b0, "R6 break held", int'(txd), 0);
        line_ctrl = 8'h03;
        #1;
        check(txd == 1'b1, "R6 frame resumes", int'(txd), 1);
        wait_to(t0 + time'(160 * P - P / 2));
        check(tx_empty == 1'b0, "R6 timing kept", int'(tx_empty), 0);
        wait_to(t0 + time'(160 * P + P / 2));
        check(tx_empty == 1'b1, "R6 frame ends on time", int'(tx_empty), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_word_len;
        t_parity;
        t_stick;
        t_stop;
        t_divisor;
        t_holding;
        t_latch;
        t_break;
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule